// File: doc/BRIEF.md
# Codirectional 64 kbit/s Transmit Encoder

This block takes one eight-bit burst of serial PCM data from a 2.048 MHz time-slot and sends it again as a continuous 64 kbit/s codirectional line signal. The signal is carried on two active-low rails. The capture side runs on the PCM bit clock. One of two time-slot envelopes frames the burst, and a select line chooses which envelope is used. The line side runs on a separate 256 kHz symbol clock that has no fixed phase relation to the PCM clock.

Each data bit takes four symbol periods. Successive bit blocks alternate between the two rails. The last bit of every octet is put on the same rail as the bit before it, and this polarity violation marks the octet boundary for the far end. An alarm request turns the violation off. The two clocks drift against each other, so whole octets are sometimes lost or sent twice. Two flags report a dropped octet and a repeated octet.

The capture side raises a toggle when an octet is complete. The toggle reaches the line side through a synchronizer. The line-side state machine has three named states:
- TX_IDLE: both rails high.
- TX_DATA: a fresh octet is being sent.
- TX_REPEAT: the previous octet is being sent again.

The state machine has these transitions:
- TX_IDLE to TX_DATA: an octet is pending.
- TX_DATA to TX_DATA: an octet is pending at the end of an octet.
- TX_DATA to TX_REPEAT: nothing is pending at the end of an octet.
- TX_REPEAT to TX_DATA: an octet is pending at the end of the repeat.
- TX_REPEAT to TX_IDLE: nothing is pending at the end of the repeat.

Top module: `cdx_tx_top`

## Requirements
- R1: When `slot_sel` is 1, `slot1_env` frames capture. When `slot_sel` is 0, `slot2_env` frames capture. Activity on the envelope that is not selected produces no octet.
- R2: Capture takes one bit of `pcm_in` on each rising `pcm_clk` edge while the selected envelope is high, eight bits in all. The first bit captured is the first bit transmitted.
- R3: Each bit block has four symbols, and all marks in a block are on one rail. A 0 bit drives the rail low, high, low, high. A 1 bit drives it low, low, high, high.
- R4: For the first seven bits of an octet, each bit block is on the rail opposite to the block before it.
- R5: With `alarm_req` low, the block for the eighth bit is on the same rail as the block for the seventh bit.
- R6: With `alarm_req` high, the block for the eighth bit is on the rail opposite to the block for the seventh bit.
- R7: An octet that is being sent is never cut short. A pending octet starts only after all 32 symbols of the current octet.
- R8: If a second octet arrives before the pending one has been taken, the pending one is dropped. `del_flag` is then high for the whole of the next octet sent.
- R9: If no octet is pending when an octet ends after fresh data, the same octet is sent once more. `ins_flag` is high for all of that repeat.
- R10: An octet is repeated only once. If there is still no data after the repeat, both rails stay high.
- R11: While `rst_n` is low, both rails are high and both flags are low.
- R12: The two rails are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcm_clk | input | 1 | PCM bit clock (2.048 MHz in use) |
| sym_clk | input | 1 | Line symbol clock (256 kHz in use), not related to pcm_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pcm_in | input | 1 | Serial PCM data |
| slot1_env | input | 1 | Time-slot envelope 1 |
| slot2_env | input | 1 | Time-slot envelope 2 |
| slot_sel | input | 1 | 1 selects slot1_env, 0 selects slot2_env |
| alarm_req | input | 1 | High suppresses the octet-boundary violation |
| tx_pos_n | output | 1 | Positive rail, active low |
| tx_neg_n | output | 1 | Negative rail, active low |
| ins_flag | output | 1 | High while a repeated octet is sent |
| del_flag | output | 1 | High while the octet that followed a dropped one is sent |

## Verification
The hardest case to reach from the ports is a deletion. Two complete octets must cross the clock boundary while an earlier octet is still on the line, and this depends on timing across both clocks. The stimulus therefore sends a first octet and lets it start. It then sends two more bursts roughly 260 ns apart, well inside the 640 ns octet time of the symbol clock. The scoreboard expects the first octet, then the third octet with the deletion flag set, and then a flagged repeat of the third octet. A burst on the envelope that is not selected is placed while a repeat is due. If that burst were captured, the repeat would be replaced, and the sequence would no longer match the scoreboard.

// File: rtl/cdx_pkg.sv
package cdx_pkg;
    localparam int PH_N = 4;              // symbols per coded bit
    localparam int PH_W = $clog2(PH_N);

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_DATA,
        TX_REPEAT
    } tx_state_e;
endpackage

// File: rtl/cdx_capture.sv
module cdx_capture #(
    parameter int OCT_W = 8
) (
    input  logic             pcm_clk,
    input  logic             rst_n,
    input  logic             pcm_in,
    input  logic             slot1_env,
    input  logic             slot2_env,
    input  logic             slot_sel,
    output logic [OCT_W-1:0] latch_q,
    output logic             tog_q
);
    localparam int CNT_W = $clog2(OCT_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OCT_W - 1);

    logic             env;
    logic [OCT_W-1:0] sh_q;
    logic [CNT_W-1:0] cnt_q;

    assign env = slot_sel ? slot1_env : slot2_env;

    always_ff @(posedge pcm_clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            latch_q <= '0;
            tog_q   <= 1'b0;
        end else if (env) begin
            sh_q <= {sh_q[OCT_W-2:0], pcm_in};
            if (cnt_q == LAST) begin
                latch_q <= {sh_q[OCT_W-2:0], pcm_in};
                tog_q   <= ~tog_q;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/cdx_sync.sv
module cdx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= '0;
                else        r_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= '0;
                else        r_q <= {r_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = r_q[STAGES-1];
endmodule

// File: rtl/cdx_encoder.sv
module cdx_encoder
    import cdx_pkg::*;
#(
    parameter int OCT_W = 8
) (
    input  logic                     sym_clk,
    input  logic                     rst_n,
    input  logic                     tog_s,
    input  logic [OCT_W-1:0]         latch_d,
    input  logic                     alarm_s,
    output logic                     tx_pos_n,
    output logic                     tx_neg_n,
    output logic                     ins_flag,
    output logic                     del_flag,
    output logic [PH_W-1:0]          phase_o,
    output logic [$clog2(OCT_W)-1:0] bit_o,
    output logic                     active_o
);
    localparam int BIT_W = $clog2(OCT_W);
    localparam logic [BIT_W-1:0] LAST    = BIT_W'(OCT_W - 1);
    localparam logic [BIT_W-1:0] PENULT  = BIT_W'(OCT_W - 2);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PH_N - 1);

    tx_state_e        st_q, st_n;
    logic             tog_d;
    logic [OCT_W-1:0] stage_q, oct_q, last_q;
    logic             pend_q, del_pend_q;
    logic [PH_W-1:0]  phase_q;
    logic [BIT_W-1:0] bitn_q;
    logic             pol_q, ins_q, del_q;
    logic             new_oct, blk_end, oct_end, need_oct, load, mark;

    assign new_oct  = tog_s ^ tog_d;
    assign blk_end  = (st_q != TX_IDLE) && (phase_q == PH_LAST);
    assign oct_end  = blk_end && (bitn_q == LAST);
    assign need_oct = (st_q == TX_IDLE) || oct_end;
    assign load     = need_oct && pend_q;

    // next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            TX_IDLE:   if (pend_q)  st_n = TX_DATA;
            TX_DATA:   if (oct_end) st_n = pend_q ? TX_DATA : TX_REPEAT;
            TX_REPEAT: if (oct_end) st_n = pend_q ? TX_DATA : TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge sym_clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_n;
    end

    // handover, slip bookkeeping and symbol sequencing
    always_ff @(posedge sym_clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_d      <= 1'b0;
            stage_q    <= '0;
            pend_q     <= 1'b0;
            del_pend_q <= 1'b0;
            oct_q      <= '0;
            last_q     <= '0;
            phase_q    <= '0;
            bitn_q     <= '0;
            pol_q      <= 1'b0;
            ins_q      <= 1'b0;
            del_q      <= 1'b0;
        end else begin
            tog_d <= tog_s;
            if (new_oct) stage_q <= latch_d;

            if (new_oct)   pend_q <= 1'b1;
            else if (load) pend_q <= 1'b0;

            if (new_oct && pend_q && !load) del_pend_q <= 1'b1;
            else if (load)                  del_pend_q <= 1'b0;

            if (load) begin
                oct_q   <= stage_q;
                last_q  <= stage_q;
                ins_q   <= 1'b0;
                del_q   <= del_pend_q;
                phase_q <= '0;
                bitn_q  <= '0;
                pol_q   <= ~pol_q;
            end else if (oct_end && st_q == TX_DATA) begin
                oct_q   <= last_q;
                ins_q   <= 1'b1;
                del_q   <= 1'b0;
                phase_q <= '0;
                bitn_q  <= '0;
                pol_q   <= ~pol_q;
            end else if (oct_end) begin
                ins_q   <= 1'b0;
                del_q   <= 1'b0;
                phase_q <= '0;
                bitn_q  <= '0;
            end else if (blk_end) begin
                phase_q <= '0;
                bitn_q  <= bitn_q + 1'b1;
                oct_q   <= oct_q << 1;
                pol_q   <= (bitn_q == PENULT && !alarm_s) ? pol_q : ~pol_q;
            end else if (st_q != TX_IDLE) begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        if (st_q == TX_IDLE) mark = 1'b0;
        else if (oct_q[OCT_W-1]) mark = ~phase_q[1];
        else mark = ~phase_q[0];
        tx_pos_n = ~(mark & ~pol_q);
        tx_neg_n = ~(mark & pol_q);
        ins_flag = ins_q;
        del_flag = del_q;
        phase_o  = phase_q;
        bit_o    = bitn_q;
        active_o = (st_q != TX_IDLE);
    end
endmodule

// File: rtl/cdx_tx_top.sv
module cdx_tx_top
    import cdx_pkg::*;
#(
    parameter int OCT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic pcm_clk,
    input  logic sym_clk,
    input  logic rst_n,
    input  logic pcm_in,
    input  logic slot1_env,
    input  logic slot2_env,
    input  logic slot_sel,
    input  logic alarm_req,
    output logic tx_pos_n,
    output logic tx_neg_n,
    output logic ins_flag,
    output logic del_flag
);
    localparam int BIT_W = $clog2(OCT_W);

    logic [OCT_W-1:0] latch_q;
    logic             tog_q, tog_s, alarm_s;
    logic [PH_W-1:0]  enc_phase;
    logic [BIT_W-1:0] enc_bit;
    logic             enc_active;

    cdx_capture #(.OCT_W(OCT_W)) u_cap (
        .pcm_clk  (pcm_clk),
        .rst_n    (rst_n),
        .pcm_in   (pcm_in),
        .slot1_env(slot1_env),
        .slot2_env(slot2_env),
        .slot_sel (slot_sel),
        .latch_q  (latch_q),
        .tog_q    (tog_q)
    );

    cdx_sync #(.STAGES(SYNC_STAGES)) u_sync_tog (
        .clk(sym_clk), .rst_n(rst_n), .d(tog_q), .q(tog_s)
    );

    cdx_sync #(.STAGES(SYNC_STAGES)) u_sync_alm (
        .clk(sym_clk), .rst_n(rst_n), .d(alarm_req), .q(alarm_s)
    );

    cdx_encoder #(.OCT_W(OCT_W)) u_enc (
        .sym_clk (sym_clk),
        .rst_n   (rst_n),
        .tog_s   (tog_s),
        .latch_d (latch_q),
        .alarm_s (alarm_s),
        .tx_pos_n(tx_pos_n),
        .tx_neg_n(tx_neg_n),
        .ins_flag(ins_flag),
        .del_flag(del_flag),
        .phase_o (enc_phase),
        .bit_o   (enc_bit),
        .active_o(enc_active)
    );
endmodule

// File: rtl/cdx_tx_chk.sv
module cdx_tx_chk
    import cdx_pkg::*;
#(
    parameter int OCT_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pos_n,
    input logic                     neg_n,
    input logic                     ins,
    input logic                     del,
    input logic [PH_W-1:0]          phase,
    input logic [$clog2(OCT_W)-1:0] bitn,
    input logic                     active
);
    localparam logic [$clog2(OCT_W)-1:0] LAST = ($clog2(OCT_W))'(OCT_W - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

    logic oct_end;
    assign oct_end = active && phase == PH_LAST && bitn == LAST;

    a_r12_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pos_n && !neg_n));

    a_r3_pos_run_one_rail: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_n |-> !$past(!neg_n));

    a_r3_neg_run_one_rail: assert property (@(posedge clk) disable iff (!rst_n)
        !neg_n |-> !$past(!pos_n));

    a_r9_ins_whole_octet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ins) |-> (phase == '0 && bitn == '0));

    a_r8_del_whole_octet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(del) |-> (phase == '0 && bitn == '0));

    a_r10_single_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && oct_end) |=> !ins);
endmodule

bind cdx_tx_top cdx_tx_chk #(.OCT_W(OCT_W)) u_chk (
    .clk   (sym_clk),
    .rst_n (rst_n),
    .pos_n (tx_pos_n),
    .neg_n (tx_neg_n),
    .ins   (ins_flag),
    .del   (del_flag),
    .phase (enc_phase),
    .bitn  (enc_bit),
    .active(enc_active)
);

// File: tb/sim_cdx_tx_top.sv
module sim_cdx_tx_top;
    logic pcm_clk = 1'b0;
    logic sym_clk = 1'b0;
    logic rst_n = 1'b0;
    logic pcm_in = 1'b0, slot1_env = 1'b0, slot2_env = 1'b0, slot_sel = 1'b1, alarm_req = 1'b0;
    logic tx_pos_n, tx_neg_n, ins_flag, del_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected item: {alarm, del, ins, data[7:0]}
    logic [10:0] exp_q[$];

    always #4 pcm_clk = ~pcm_clk;              // 125 MHz
    initial begin #3; forever #10 sym_clk = ~sym_clk; end

    cdx_tx_top u0 (
        .pcm_clk(pcm_clk), .sym_clk(sym_clk), .rst_n(rst_n), .pcm_in(pcm_in),
        .slot1_env(slot1_env), .slot2_env(slot2_env), .slot_sel(slot_sel),
        .alarm_req(alarm_req), .tx_pos_n(tx_pos_n), .tx_neg_n(tx_neg_n),
        .ins_flag(ins_flag), .del_flag(del_flag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_oct(input logic [7:0] d, input bit ins, input bit del, input bit alm);
        exp_q.push_back({alm, del, ins, d});
    endtask

    task automatic send_octet(input logic [7:0] d, input bit use2);
        for (int i = 0; i < 8; i++) begin
            @(negedge pcm_clk);
            if (use2) slot2_env = 1'b1; else slot1_env = 1'b1;
            pcm_in = d[7-i];
        end
        @(negedge pcm_clk);
        slot1_env = 1'b0;
        slot2_env = 1'b0;
        pcm_in    = 1'b0;
    endtask

    task automatic idle_check(input string req);
        int lows = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge sym_clk);
            if (!tx_pos_n || !tx_neg_n) lows++;
        end
        chk(lows == 0, req, "rails not idle high", lows, 0);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (40) @(negedge sym_clk);
    endtask

    // monitor / scoreboard
    initial begin
        logic [7:0] data;
        bit         rail [8];
        bit         m    [4];
        bit         pat_ok, ins_ok, del_ok;
        bit         r;
        logic [10:0] e;
        forever begin
            @(negedge sym_clk);
            if (rst_n && (!tx_pos_n || !tx_neg_n)) begin
                pat_ok = 1'b1; ins_ok = 1'b1; del_ok = 1'b1;
                if (exp_q.size() != 0) e = exp_q[0]; else e = '0;
                for (int k = 0; k < 8; k++) begin
                    for (int p = 0; p < 4; p++) begin
                        if (k != 0 || p != 0) @(negedge sym_clk);
                        m[p] = !tx_pos_n || !tx_neg_n;
                        if (p == 0) r = !tx_neg_n;
                        else if (m[p] && (!tx_neg_n) != r) pat_ok = 1'b0;
                        if (ins_flag != e[8]) ins_ok = 1'b0;
                        if (del_flag != e[9]) del_ok = 1'b0;
                    end
                    rail[k] = r;
                    data[7-k] = m[1];
                    if (!(m[0] && !m[3] && (m[1] ? !m[2] : m[2]))) pat_ok = 1'b0;
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected octet", data, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(data == e[7:0], "R2", "octet data", data, e[7:0]);
                    chk(pat_ok, "R3", "symbol pattern", 0, 1);
                    chk(ins_ok, "R9", "ins_flag over octet", !e[8], e[8]);
                    chk(del_ok, "R8", "del_flag over octet", !e[9], e[9]);
                    for (int k = 1; k < 7; k++)
                        chk(rail[k] != rail[k-1], "R4", "alternation", rail[k], !rail[k-1]);
                    if (e[10])
                        chk(rail[7] != rail[6], "R6", "alarm: no violation", rail[7], !rail[6]);
                    else
                        chk(rail[7] == rail[6], "R5", "octet violation", rail[7], rail[6]);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge pcm_clk);
        if (!done) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (5) @(negedge sym_clk);
        chk(tx_pos_n && tx_neg_n, "R11", "rails in reset", {tx_pos_n, tx_neg_n}, 3);
        chk(!ins_flag && !del_flag, "R11", "flags in reset", {ins_flag, del_flag}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge sym_clk);

        // single octet on slot 1: sent, repeated once (R9), then idle (R10)
        slot_sel = 1'b1;
        expect_oct(8'hA5, 0, 0, 0);
        expect_oct(8'hA5, 1, 0, 0);
        send_octet(8'hA5, 0);
        drain();
        idle_check("R10");

        // deletion: 0F overwritten by E1 while 3C is on the line (R7, R8)
        expect_oct(8'h3C, 0, 0, 0);
        expect_oct(8'hE1, 0, 1, 0);
        expect_oct(8'hE1, 1, 0, 0);
        send_octet(8'h3C, 0);
        #200;
        send_octet(8'h0F, 0);
        #200;
        send_octet(8'hE1, 0);
        drain();
        idle_check("R10");

        // slot 2 selected; a burst on slot 1 must be ignored (R1)
        slot_sel = 1'b0;
        expect_oct(8'h5A, 0, 0, 0);
        expect_oct(8'h96, 0, 0, 0);
        expect_oct(8'h96, 1, 0, 0);
        send_octet(8'h5A, 1);
        #200;
        send_octet(8'h96, 1);
        #700;
        send_octet(8'hFF, 0);   // R1 decoy on the unselected envelope
        drain();
        idle_check("R1");

        // alarm suppresses the boundary violation (R6)
        alarm_req = 1'b1;
        repeat (10) @(negedge sym_clk);
        expect_oct(8'hC5, 0, 0, 1);
        expect_oct(8'hC5, 1, 0, 1);
        send_octet(8'hC5, 1);
        drain();
        alarm_req = 1'b0;
        repeat (10) @(negedge sym_clk);

        // all-zero and all-one back to back
        expect_oct(8'h00, 0, 0, 0);
        expect_oct(8'hFF, 0, 0, 0);
        expect_oct(8'hFF, 1, 0, 0);
        send_octet(8'h00, 1);
        #200;
        send_octet(8'hFF, 1);
        drain();
        idle_check("R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule